// File: doc/BRIEF.md
# PHY Link Configuration Sequencer

This block brings an Ethernet PHY into service through a simple management request port, then sets the MAC's speed, duplex and inter-packet-gap outputs to match the link the PHY reports. A one-cycle `start` pulse with a mode code launches a fixed sequence. First the sequencer reads both PHY identifier registers and proceeds only if they match the expected values. Next it makes one write to the PHY control register. It then polls the status register, first for auto-negotiation completion (auto mode only) and then for link. Last, it resolves speed and duplex from the five ability bits of the final status word. The sequence ends with a one-cycle `done` or `error` pulse.

Serial shifting on the management wire is left to a separate management master. The sequencer issues one request at a time as a single-cycle `mgmt_req`. `mgmt_we` and `mgmt_addr` say which register is meant, and `mgmt_wdata` carries the write value. The master answers with a one-cycle `mgmt_done` in a later cycle, with `mgmt_rdata` valid in that cycle for reads.

States:
- `S_IDLE`: waits for `start`.
- `S_RD_ID1` and `S_WT_ID1`: issue and await the first identifier read.
- `S_RD_ID2` and `S_WT_ID2`: issue and await the second identifier read.
- `S_WR_CTL` and `S_WT_CTL`: issue and await the control write.
- `S_RD_AN` and `S_WT_AN`: poll for auto-negotiation completion.
- `S_RD_LNK` and `S_WT_LNK`: poll for link.
- `S_APPLY`: loads the MAC settings.
- `S_FIN_OK`: pulses `done`.
- `S_FIN_ERR`: pulses `error`.

Transitions:
- `S_IDLE` to `S_RD_ID1` on `start`.
- Each read or write state to its wait state after one cycle.
- `S_WT_ID1` to `S_RD_ID2` on `mgmt_done`.
- `S_WT_ID2` to `S_WR_CTL` when the identity matches and the mode is valid, otherwise to `S_FIN_ERR`.
- `S_WT_CTL` to `S_RD_AN` in auto mode, otherwise to `S_RD_LNK`.
- `S_WT_AN` to `S_RD_LNK` on the completion bit, back to `S_RD_AN` while budget remains, otherwise to `S_FIN_ERR`.
- `S_WT_LNK` to `S_APPLY` on the link bit, back to `S_RD_LNK` while budget remains, otherwise to `S_FIN_ERR`.
- `S_APPLY` to `S_FIN_OK`.
- `S_FIN_OK` and `S_FIN_ERR` to `S_IDLE`.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mgmt_req`, `done`, `error`, `mac_full_duplex`, `cmd_full_duplex` and `mac_speed_100` are 0, and `mac_ipg` is 0.
- R2: A `start` pulse causes a read of register 2 (first identifier) and then a read of register 3 (second identifier). Every `mgmt_req` lasts one cycle, and no new request is issued before `mgmt_done` answers the previous one.
- R3: If the first identifier differs from `ID1_EXPECT`, or bits 15:4 of the second identifier differ from `ID2_EXPECT`, the run ends with `error` and no write is issued. Bits 3:0 of the second identifier are ignored.
- R4: Mode codes are 0 auto, 1 10M full, 2 10M half, 3 100M full and 4 100M half. Codes 5 to 7 end the run with `error` after the two identifier reads, with no write.
- R5: For a valid mode, exactly one write goes to register 0. The value is 0x1200 for auto (bit 12 enable, bit 9 restart). For the fixed modes, bit 13 is set for 100M and bit 8 for full duplex, giving 0x0100, 0x0000, 0x2100 and 0x2000 for codes 1 to 4.
- R6: In auto mode the block reads register 1 (status) until bit 5 is set. If `POLL_LIMIT` such reads complete without bit 5, the run ends with `error`. Fixed modes skip this phase.
- R7: The block then reads status until bit 2 (link) is set, with a fresh budget of `POLL_LIMIT` reads. If the budget is exhausted, the run ends with `error`.
- R8: Duplex is resolved from the status word that showed link. If bit 14 or bit 12 is set, full duplex is chosen: both duplex outputs are driven to 1 and `mac_ipg` is set to 0x15. Otherwise, if bit 13 or bit 11 is set, half duplex is chosen: both duplex outputs are driven to 0 and `mac_ipg` is set to 0x12.
- R9: Speed is resolved from the same word. If bit 15, 14 or 13 is set, `mac_speed_100` is driven to 1. Otherwise, if bit 12 or bit 11 is set, it is driven to 0.
- R10: Settings the status word does not decide (no duplex ability bit, no speed ability bit) keep their previous values. A run ending in `error` changes no MAC setting.
- R11: `done` and `error` are one-cycle pulses, exactly one per run. `busy` is high from the cycle after `start` until the pulse, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| mode | input | 3 | Requested link mode code |
| busy | output | 1 | Sequence in progress |
| mgmt_req | output | 1 | One-cycle management request |
| mgmt_we | output | 1 | Request is a write |
| mgmt_addr | output | ADDR_W | PHY register address |
| mgmt_wdata | output | 16 | Write value |
| mgmt_done | input | 1 | Request completed |
| mgmt_rdata | input | 16 | Read value, valid with `mgmt_done` |
| mac_full_duplex | output | 1 | MAC full-duplex setting |
| cmd_full_duplex | output | 1 | Command-path full-duplex setting |
| mac_speed_100 | output | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| mac_ipg | output | IPG_W | Back-to-back inter-packet-gap value |
| done | output | 1 | Successful completion pulse |
| error | output | 1 | Failure pulse |

## Verification
The hardest cases to reach are the poll timeouts at their exact edges. One case is a success on the last allowed status read. Another is a run where auto-negotiation completes late, so the link phase must start a fresh budget rather than inherit the spent one. A bare bus cannot produce these, so the bench's PHY responder counts status reads per run. It raises the completion and link bits only from a programmed read index onwards. The bench sweeps both indices across and beyond the poll limit, and checks the verdict and the exact number of status reads against arithmetic on those indices.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int DATA_W = 16;

    localparam logic [4:0] REG_CTL  = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;
    localparam logic [4:0] REG_ID1  = 5'd2;
    localparam logic [4:0] REG_ID2  = 5'd3;

    localparam int ST_AN_DONE = 5;
    localparam int ST_LINK    = 2;
    localparam int ST_ABIL_LO = 11;

    localparam int CTL_SPEED   = 13;
    localparam int CTL_AN_EN   = 12;
    localparam int CTL_RESTART = 9;
    localparam int CTL_DUPLEX  = 8;

    localparam logic [2:0] MODE_AUTO = 3'd0;
    localparam logic [2:0] MODE_10F  = 3'd1;
    localparam logic [2:0] MODE_10H  = 3'd2;
    localparam logic [2:0] MODE_100F = 3'd3;
    localparam logic [2:0] MODE_100H = 3'd4;

    localparam logic [7:0] IPG_FULL = 8'h15;
    localparam logic [7:0] IPG_HALF = 8'h12;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ID1,
        S_WT_ID1,
        S_RD_ID2,
        S_WT_ID2,
        S_WR_CTL,
        S_WT_CTL,
        S_RD_AN,
        S_WT_AN,
        S_RD_LNK,
        S_WT_LNK,
        S_APPLY,
        S_FIN_OK,
        S_FIN_ERR
    } seq_state_t;

    typedef struct packed {
        logic is_full;
        logic is_half;
        logic is_100;
        logic is_10;
    } link_res_t;

endpackage

// File: rtl/ctl_word_encode.sv
module ctl_word_encode
    import phy_seq_pkg::*;
(
    input  logic [2:0]        mode,
    output logic              valid,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        valid = 1'b1;
        word  = '0;
        unique case (mode)
            MODE_AUTO: begin
                word[CTL_AN_EN]   = 1'b1;
                word[CTL_RESTART] = 1'b1;
            end
            MODE_10F:  word[CTL_DUPLEX] = 1'b1;
            MODE_10H:  word = '0;
            MODE_100F: begin
                word[CTL_SPEED]  = 1'b1;
                word[CTL_DUPLEX] = 1'b1;
            end
            MODE_100H: word[CTL_SPEED] = 1'b1;
            default:   valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ability_resolver.sv
module ability_resolver
    import phy_seq_pkg::*;
(
    input  logic [4:0] abil,
    output link_res_t  res
);
    logic b100t4, b100f, b100h, b10f, b10h;

    assign {b100t4, b100f, b100h, b10f, b10h} = abil;

    always_comb begin
        res.is_full = b100f | b10f;
        res.is_half = b100h | b10h;
        res.is_100  = b100t4 | b100f | b100h;
        res.is_10   = b10f | b10h;
    end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last = (count_q == CNT_W'(LIMIT - 1));

    // R6 / R7: a tick is only granted while budget remains
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |-> !last);

    // R7: the count never passes the limit
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_q) < LIMIT);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          IPG_W      = 7,
    parameter int          POLL_LIMIT = 8,
    parameter logic [15:0] ID1_EXPECT = 16'h2000,
    parameter logic [11:0] ID2_EXPECT = 12'h5C9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    output logic              busy,
    output logic              mgmt_req,
    output logic              mgmt_we,
    output logic [ADDR_W-1:0] mgmt_addr,
    output logic [DATA_W-1:0] mgmt_wdata,
    input  logic              mgmt_done,
    input  logic [DATA_W-1:0] mgmt_rdata,
    output logic              mac_full_duplex,
    output logic              cmd_full_duplex,
    output logic              mac_speed_100,
    output logic [IPG_W-1:0]  mac_ipg,
    output logic              done,
    output logic              error
);
    localparam logic [IPG_W-1:0] GAP_FULL = IPG_W'(IPG_FULL);
    localparam logic [IPG_W-1:0] GAP_HALF = IPG_W'(IPG_HALF);

    seq_state_t state_q, state_d;
    logic [2:0]        mode_q;
    logic [DATA_W-1:0] id1_q;
    logic [4:0]        abil_q;
    logic              mode_ok;
    logic [DATA_W-1:0] ctl_word;
    logic              poll_last;
    logic              poll_clear;
    logic              poll_tick;
    logic              id_match;
    link_res_t         res;

    ctl_word_encode u_enc (
        .mode  (mode_q),
        .valid (mode_ok),
        .word  (ctl_word)
    );

    ability_resolver u_res (
        .abil (abil_q),
        .res  (res)
    );

    poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .tick  (poll_tick),
        .last  (poll_last)
    );

    assign id_match = (id1_q == ID1_EXPECT) && (mgmt_rdata[15:4] == ID2_EXPECT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_RD_ID1;
            S_RD_ID1: state_d = S_WT_ID1;
            S_WT_ID1: if (mgmt_done) state_d = S_RD_ID2;
            S_RD_ID2: state_d = S_WT_ID2;
            S_WT_ID2: if (mgmt_done) state_d = (id_match && mode_ok) ? S_WR_CTL : S_FIN_ERR;
            S_WR_CTL: state_d = S_WT_CTL;
            S_WT_CTL: if (mgmt_done) state_d = (mode_q == MODE_AUTO) ? S_RD_AN : S_RD_LNK;
            S_RD_AN:  state_d = S_WT_AN;
            S_WT_AN: begin
                if (mgmt_done) begin
                    if (mgmt_rdata[ST_AN_DONE]) state_d = S_RD_LNK;
                    else if (poll_last)         state_d = S_FIN_ERR;
                    else                        state_d = S_RD_AN;
                end
            end
            S_RD_LNK: state_d = S_WT_LNK;
            S_WT_LNK: begin
                if (mgmt_done) begin
                    if (mgmt_rdata[ST_LINK]) state_d = S_APPLY;
                    else if (poll_last)      state_d = S_FIN_ERR;
                    else                     state_d = S_RD_LNK;
                end
            end
            S_APPLY:   state_d = S_FIN_OK;
            S_FIN_OK:  state_d = S_IDLE;
            S_FIN_ERR: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // poll budget control
    always_comb begin
        poll_clear = (state_q == S_IDLE) || (state_q == S_WT_CTL) ||
                     (state_q == S_WT_AN && mgmt_done && mgmt_rdata[ST_AN_DONE]);
        poll_tick  = mgmt_done && !poll_last &&
                     ((state_q == S_WT_AN  && !mgmt_rdata[ST_AN_DONE]) ||
                      (state_q == S_WT_LNK && !mgmt_rdata[ST_LINK]));
    end

    // request and status outputs
    always_comb begin
        mgmt_req   = 1'b0;
        mgmt_we    = 1'b0;
        mgmt_addr  = '0;
        mgmt_wdata = '0;
        unique case (state_q)
            S_RD_ID1: begin mgmt_req = 1'b1; mgmt_addr = ADDR_W'(REG_ID1); end
            S_RD_ID2: begin mgmt_req = 1'b1; mgmt_addr = ADDR_W'(REG_ID2); end
            S_WR_CTL: begin
                mgmt_req   = 1'b1;
                mgmt_we    = 1'b1;
                mgmt_addr  = ADDR_W'(REG_CTL);
                mgmt_wdata = ctl_word;
            end
            S_RD_AN, S_RD_LNK: begin mgmt_req = 1'b1; mgmt_addr = ADDR_W'(REG_STAT); end
            default: ;
        endcase
        busy  = (state_q != S_IDLE);
        done  = (state_q == S_FIN_OK);
        error = (state_q == S_FIN_ERR);
    end

    // captured data and MAC settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q          <= '0;
            id1_q           <= '0;
            abil_q          <= '0;
            mac_full_duplex <= 1'b0;
            cmd_full_duplex <= 1'b0;
            mac_speed_100   <= 1'b0;
            mac_ipg         <= '0;
        end else begin
            if (state_q == S_IDLE && start)     mode_q <= mode;
            if (state_q == S_WT_ID1 && mgmt_done) id1_q <= mgmt_rdata;
            if (state_q == S_WT_LNK && mgmt_done) abil_q <= mgmt_rdata[ST_ABIL_LO +: 5];
            if (state_q == S_APPLY) begin
                if (res.is_full) begin
                    mac_full_duplex <= 1'b1;
                    cmd_full_duplex <= 1'b1;
                    mac_ipg         <= GAP_FULL;
                end else if (res.is_half) begin
                    mac_full_duplex <= 1'b0;
                    cmd_full_duplex <= 1'b0;
                    mac_ipg         <= GAP_HALF;
                end
                if (res.is_100)     mac_speed_100 <= 1'b1;
                else if (res.is_10) mac_speed_100 <= 1'b0;
            end
        end
    end

    // R2: requests are single-cycle pulses
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req |=> !mgmt_req);

    // R5: writes only ever target the control register
    assert_write_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && mgmt_we) |-> (mgmt_addr == ADDR_W'(REG_CTL)));

    // R10: MAC settings change only right before a done pulse
    assert_settings_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(mac_ipg) && $stable(mac_speed_100) && $stable(mac_full_duplex)) |-> done);

    // R8: the two duplex outputs agree
    assert_duplex_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mac_full_duplex == cmd_full_duplex);

    // R11: busy rises only in answer to start
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11: completion pulses last one cycle and never overlap
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error));
endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 4;
    localparam logic [15:0] ID1V = 16'h2000;
    localparam logic [11:0] ID2V = 12'h5C9;

    logic clk = 0, rst_n = 0, start = 0;
    logic [2:0] mode_in = 0;
    logic busy, mgmt_req, mgmt_we, mgmt_done;
    logic [4:0] mgmt_addr;
    logic [15:0] mgmt_wdata, mgmt_rdata;
    logic mfd, cfd, spd, done, error;
    logic [6:0] ipg;

    phy_bringup_seq #(.POLL_LIMIT(LIM), .ID1_EXPECT(ID1V), .ID2_EXPECT(ID2V)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_in), .busy(busy),
        .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata),
        .mac_full_duplex(mfd), .cmd_full_duplex(cfd), .mac_speed_100(spd),
        .mac_ipg(ipg), .done(done), .error(error));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // responder configuration and statistics
    logic [15:0] id1_val = ID1V, id2_val = {ID2V, 4'h0};
    logic [4:0]  abil = 0;
    int an_after = 0, lnk_after = 0, lat = 0;
    int n_req = 0, n_wr = 0, n_sread = 0, overlap = 0, base_sread = 0;
    logic [15:0] last_wd = 0;
    logic [4:0] rec_addr [64];
    logic       rec_we [64];
    int n_done = 0, n_err = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // PHY management responder
    initial begin
        mgmt_done = 0;
        mgmt_rdata = 0;
        forever begin
            @(negedge clk);
            mgmt_done = 0;
            if (mgmt_req) begin
                logic [4:0] a;
                logic w;
                logic [15:0] d;
                int idx;
                a = mgmt_addr; w = mgmt_we; d = mgmt_wdata;
                rec_addr[n_req % 64] = a;
                rec_we[n_req % 64] = w;
                n_req++;
                for (int k = 0; k < lat + 1; k++) begin
                    @(negedge clk);
                    if (mgmt_req) overlap++;
                end
                mgmt_rdata = 16'h0;
                if (w) begin
                    n_wr++;
                    last_wd = d;
                end else if (a == 5'd2) mgmt_rdata = id1_val;
                else if (a == 5'd3) mgmt_rdata = id2_val;
                else if (a == 5'd1) begin
                    idx = n_sread - base_sread;
                    n_sread++;
                    mgmt_rdata = {abil, 11'b0};
                    if (idx >= an_after)  mgmt_rdata[5] = 1'b1;
                    if (idx >= lnk_after) mgmt_rdata[2] = 1'b1;
                end
                mgmt_done = 1;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done) n_done++;
            if (error) n_err++;
        end
    end

    // expected MAC settings (R8, R9, R10)
    logic e_fd = 0, e_spd = 0;
    logic [6:0] e_ipg = 0;

    task automatic run_case(input logic [2:0] m, input logic [4:0] ab, input int an_a,
                            input int lk_a, input bit restart);
        int b_req, b_wr, b_done, b_err, b_ovl, t, exp_sr, li;
        bit exp_ok, id_ok, m_ok;
        logic [15:0] exp_wd;
        abil = ab; an_after = an_a; lnk_after = lk_a;
        b_req = n_req; b_wr = n_wr; b_done = n_done; b_err = n_err; b_ovl = overlap;
        base_sread = n_sread;
        @(negedge clk);
        start = 1; mode_in = m;
        @(negedge clk);
        start = 0;
        if (restart) begin
            repeat (2) @(negedge clk);
            start = 1; mode_in = 3'd7;
            @(negedge clk);
            start = 0;
        end
        t = 0;
        while (!(done || error) && t < 600) begin
            @(negedge clk);
            t++;
        end
        id_ok = (id1_val == ID1V) && (id2_val[15:4] == ID2V);
        m_ok = (m < 3'd5);
        exp_ok = 0; exp_sr = 0;
        if (id_ok && m_ok) begin
            if (m == 3'd0) begin
                if (an_a >= LIM) exp_sr = LIM;
                else begin
                    li = (lk_a > an_a + 1) ? lk_a : an_a + 1;
                    if (li - an_a > LIM) exp_sr = an_a + 1 + LIM;
                    else begin exp_ok = 1; exp_sr = li + 1; end
                end
            end else begin
                if (lk_a + 1 > LIM) exp_sr = LIM;
                else begin exp_ok = 1; exp_sr = lk_a + 1; end
            end
        end
        chk("R11 done at finish", int'(done), int'(exp_ok));
        chk("R6/R7 error at finish", int'(error), int'(!exp_ok));
        if (exp_ok) begin
            if (ab[3] | ab[1])      begin e_fd = 1; e_ipg = 7'h15; end
            else if (ab[2] | ab[0]) begin e_fd = 0; e_ipg = 7'h12; end
            if (ab[4] | ab[3] | ab[2]) e_spd = 1;
            else if (ab[1] | ab[0])    e_spd = 0;
        end
        chk("R8 mac_full_duplex", int'(mfd), int'(e_fd));
        chk("R8 cmd_full_duplex", int'(cfd), int'(e_fd));
        chk("R8 mac_ipg", int'(ipg), int'(e_ipg));
        chk("R9 mac_speed_100", int'(spd), int'(e_spd));
        repeat (4) @(negedge clk);
        chk("R11 busy low after run", int'(busy), 0);
        chk("R11 one pulse per run", (n_done - b_done) + (n_err - b_err), 1);
        chk("R2 id1 address", int'(rec_addr[b_req % 64]), 2);
        chk("R2 id2 address", int'(rec_addr[(b_req + 1) % 64]), 3);
        chk("R2 no overlapping request", overlap - b_ovl, 0);
        chk("R6/R7 status reads", n_sread - base_sread, exp_sr);
        if (id_ok && m_ok) begin
            exp_wd = 16'h0;
            if (m == 3'd0) exp_wd = 16'h1200;
            else begin
                if (m == 3'd3 || m == 3'd4) exp_wd[13] = 1'b1;
                if (m == 3'd1 || m == 3'd3) exp_wd[8] = 1'b1;
            end
            chk("R5 one write", n_wr - b_wr, 1);
            chk("R5 write value", int'(last_wd), int'(exp_wd));
            chk("R5 write addr", int'(rec_addr[(b_req + 2) % 64]), 0);
        end else begin
            chk(id_ok ? "R4 no write" : "R3 no write", n_wr - b_wr, 0);
            chk(id_ok ? "R4 total requests" : "R3 total requests", n_req - b_req, 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 mgmt_req", int'(mgmt_req), 0);
        chk("R1 done/error", int'(done | error), 0);
        chk("R1 settings", int'({mfd, cfd, spd, ipg}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", int'(busy), 0);

        // R4 R5 R8 R9 R10: every mode against every ability pattern
        for (int m = 0; m < 8; m++) begin
            for (int ab = 0; ab < 32; ab++) begin
                lat = (m + ab) % 3;
                run_case(3'(m), 5'(ab), 1, 2, 0);
            end
        end
        // R6 R7: poll boundaries in auto mode
        for (int a = 0; a <= LIM + 1; a++) begin
            for (int l = 0; l <= LIM + 3; l++) begin
                lat = l % 2;
                run_case(3'd0, 5'b01000, a, l, 0);
            end
        end
        // R7: link boundary in fixed modes
        for (int l = 0; l <= LIM + 1; l++) begin
            run_case(3'd3, 5'b00100, 0, l, 0);
            run_case(3'd2, 5'b00010, 0, l, 0);
        end
        // R3: identity checks
        lat = 0;
        id1_val = 16'h2001;
        run_case(3'd0, 5'b11111, 0, 0, 0);
        id1_val = ID1V;
        id2_val = {ID2V ^ 12'h001, 4'h0};
        run_case(3'd1, 5'b11111, 0, 0, 0);
        id2_val = {ID2V ^ 12'h800, 4'h0};
        run_case(3'd3, 5'b11111, 0, 0, 0);
        for (int n = 0; n < 16; n++) begin
            id2_val = {ID2V, 4'(n)};
            run_case(3'(n % 5), 5'(n + 1), 0, 0, 0);
        end
        id2_val = {ID2V, 4'h0};
        // R11: start while busy is ignored
        for (int m = 0; m < 5; m++) begin
            lat = 1;
            run_case(3'(m), 5'b10101, 1, 2, 1);
        end
        finished = 1;
    end

    initial begin
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule